// File: doc/BRIEF.md
# Shared-Memory Slot Arbiter with Donation

This block decides, every clock cycle, which of eight cores may use a shared memory. A free-running slot counter walks through the cores in order. The core whose index matches the counter owns that cycle. When nothing else is configured, each core gets exactly its own slot and no other bandwidth.

Each core holds a small configuration word, written through a plain write port. With this word a core can hand its slot to one named recipient, in one of two modes:

- **Yield:** the recipient takes precedence over the owner.
- **Gift:** the owner keeps precedence, and the recipient is served only when the owner is idle.

A recipient must opt in before it receives any donated slot. A core may also opt in to claim slots that would otherwise pass unused. Several such claimers are served in rotation.

The grant is a one-hot vector. It is computed in the same cycle from the request lines and the current slot. The current slot is visible on `slot_o`. The block has no data stream, so all of its pins are plain control signals without handshake.

Top module: `slot_arbiter`

## Requirements
- R1: After reset every configuration word is zero and `slot_o` is 0, so only the slot owner can be granted.
- R2: `slot_o` advances by one on every clock after reset and wraps from 7 to 0.
- R3: With no donation in force for the current slot, a requesting owner is granted and no other core is granted that cycle.
- R4: Yield mode (bit 4 set, bit 3 clear): the recipient named in bits 2:0 is granted ahead of the owner whenever it requests.
- R5: Gift mode (bit 3 set): the owner is granted when it requests, and the named recipient is granted only when the owner does not request.
- R6: A word with both bit 4 and bit 3 set behaves as gift mode.
- R7: A donation has no effect unless the recipient has its accept bit (bit 6) set. Without that bit, the slot falls back to the owner or to idle reuse. A donation naming the owner itself also has no effect.
- R8: A core with its claim-idle bit (bit 5) set and its request high is granted a slot whose owner is idle and whose effective recipient is idle or absent. A requesting core without bit 5 is not granted another core's idle slot.
- R9: When several claim-idle cores compete, the winner is the first requester found by searching upward from the core after the last idle-slot winner, wrapping at 7. After reset the search starts at core 0.
- R10: At most one grant bit is high in any cycle, and the grant is all zero when no eligible core requests.
- R11: A configuration write presented in a cycle updates that core's word at the clock edge. The new word governs grants from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Per-core request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_core_i | input | 3 | Core whose word is written |
| cfg_word_i | input | 7 | Word: bit6 accept, bit5 claim-idle, bit4 yield, bit3 gift, bits2:0 recipient |
| slot_o | output | 3 | Current slot index (owner core) |
| grant_o | output | 8 | One-hot grant for this cycle |

## Verification
The grant is combinational, so it is due in the same cycle as the request pattern and slot that produce it. A configuration write or an idle-slot win first affects the grant one cycle later. The bench drives each stimulus just after a falling edge and queues the expected grant and slot at that moment. The monitor compares the outputs a nanosecond later, before the next rising edge. Only after that does the bench model apply the write, the slot advance and the round-robin pointer update, which keeps the one-cycle lag of R11 and R9 in the expected values.

// File: rtl/slot_arbiter_pkg.sv
package slot_arbiter_pkg;
  parameter int unsigned SA_CORES = 8;
  localparam int unsigned SA_IDXW = $clog2(SA_CORES);

  typedef struct packed {
    logic               accept;     // takes donated slots
    logic               take_idle;  // claims unused slots
    logic               yield_m;    // recipient ahead of owner
    logic               gift_m;     // owner ahead of recipient
    logic [SA_IDXW-1:0] rcp;        // named recipient
  } sa_cfg_t;

  localparam int unsigned SA_CFGW = $bits(sa_cfg_t);
endpackage

// File: rtl/sa_slot_ctr.sv
module sa_slot_ctr
  import slot_arbiter_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  output logic [SA_IDXW-1:0] slot_q
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      run_q  <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      if (slot_q == SA_IDXW'(SA_CORES - 1)) slot_q <= '0;
      else                                  slot_q <= slot_q + 1'b1;
    end
  end

  // R2: the slot steps by one each cycle, wrapping at the last core
  a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (slot_q == (($past(slot_q) == SA_IDXW'(SA_CORES - 1)) ? '0 : $past(slot_q) + 1'b1)));
endmodule

// File: rtl/sa_cfg_bank.sv
module sa_cfg_bank
  import slot_arbiter_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [SA_IDXW-1:0] core_i,
  input  sa_cfg_t            word_i,
  output sa_cfg_t            cfg_q [SA_CORES]
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  for (genvar g = 0; g < SA_CORES; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cfg_q[g] <= '0;
      else if (we_i && core_i == SA_IDXW'(g))      cfg_q[g] <= word_i;
    end
  end

  // R11: a write lands at the edge that follows it
  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(we_i)) |-> (cfg_q[$past(core_i)] == $past(word_i)));
endmodule

// File: rtl/sa_idle_rr.sv
module sa_idle_rr
  import slot_arbiter_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SA_CORES-1:0] cand_i,
  input  logic                take_i,
  output logic [SA_CORES-1:0] win_o,
  output logic                valid_o
);
  logic [SA_IDXW-1:0] last_q;
  logic [SA_IDXW-1:0] win_idx;

  always_comb begin
    win_o   = '0;
    valid_o = 1'b0;
    win_idx = '0;
    for (int k = 0; k < SA_CORES; k++) begin
      int j;
      j = (int'(last_q) + 1 + k) % SA_CORES;
      if (!valid_o && cand_i[j]) begin
        valid_o  = 1'b1;
        win_idx  = SA_IDXW'(j);
        win_o[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  last_q <= SA_IDXW'(SA_CORES - 1);
    else if (take_i && valid_o)  last_q <= win_idx;
  end

  // R9: the pointer moves to the core that won an idle slot
  a_r9_ptr_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && valid_o) |=> (last_q == $past(win_idx)));
  // R9: the winner is always a candidate
  a_r9_win_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o & ~cand_i) == '0);
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arbiter_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SA_CORES-1:0] req_i,
  input  logic                cfg_we_i,
  input  logic [SA_IDXW-1:0]  cfg_core_i,
  input  logic [SA_CFGW-1:0]  cfg_word_i,
  output logic [SA_IDXW-1:0]  slot_o,
  output logic [SA_CORES-1:0] grant_o
);
  sa_cfg_t             cfg_q [SA_CORES];
  logic [SA_CORES-1:0] claim_mask;
  logic [SA_CORES-1:0] idle_win;
  logic                idle_valid;
  logic                use_idle;
  sa_cfg_t             own_cfg;
  logic [SA_IDXW-1:0]  rcp;
  logic                donate;
  logic                yield_on;

  sa_slot_ctr u_ctr (.clk(clk), .rst_n(rst_n), .slot_q(slot_o));

  sa_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .core_i(cfg_core_i),
    .word_i(sa_cfg_t'(cfg_word_i)), .cfg_q(cfg_q)
  );

  for (genvar g = 0; g < SA_CORES; g++) begin : g_claim
    assign claim_mask[g] = cfg_q[g].take_idle & req_i[g];
  end

  sa_idle_rr u_rr (
    .clk(clk), .rst_n(rst_n), .cand_i(claim_mask), .take_i(use_idle),
    .win_o(idle_win), .valid_o(idle_valid)
  );

  assign own_cfg  = cfg_q[slot_o];
  assign rcp      = own_cfg.rcp;
  assign donate   = (own_cfg.yield_m | own_cfg.gift_m) & cfg_q[rcp].accept & (rcp != slot_o);
  assign yield_on = donate & own_cfg.yield_m & ~own_cfg.gift_m;

  always_comb begin
    grant_o  = '0;
    use_idle = 1'b0;
    if (yield_on && req_i[rcp])      grant_o[rcp]    = 1'b1;
    else if (req_i[slot_o])          grant_o[slot_o] = 1'b1;
    else if (donate && req_i[rcp])   grant_o[rcp]    = 1'b1;
    else if (idle_valid) begin
      grant_o  = idle_win;
      use_idle = 1'b1;
    end
  end

  // R10: never more than one grant
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o));
  // R10: only requesting cores are granted
  a_r10_req_only: assert property (@(posedge clk) disable iff (!rst_n) (grant_o & ~req_i) == '0);
  // R3: an owner with no active donation is never passed over
  a_r3_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[slot_o] && !donate) |-> grant_o[slot_o]);
  // R8: core without claim-idle never takes a slot it neither owns nor receives
  a_r8_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~claim_mask & ~(SA_CORES'(1) << slot_o) & ~(SA_CORES'(1) << rcp)) == '0);
endmodule

// File: tb/slot_arbiter_bench.sv
module slot_arbiter_bench;
  typedef struct {
    logic [7:0] grant;
    int         slot;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_core = '0;
  logic [6:0] cfg_word = '0;
  logic [2:0] slot;
  logic [7:0] grant;

  int checks = 0;
  int failures = 0;
  exp_t q[$];

  logic [6:0] mcfg [8];
  int mslot = 0;
  int mlast = 7;

  always #2.5 clk = ~clk;

  slot_arbiter u_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_we_i(cfg_we),
    .cfg_core_i(cfg_core), .cfg_word_i(cfg_word), .slot_o(slot), .grant_o(grant)
  );

  // model of the requirements: returns expected grant, flags idle use
  task automatic model(input logic [7:0] r, output logic [7:0] g, output int idle_w);
    logic [6:0] c;
    int rc;
    bit don, yl;
    c = mcfg[mslot];
    rc = int'(c[2:0]);
    don = (c[4] | c[3]) && mcfg[rc][6] && (rc != mslot);   // R6 R7
    yl = don && c[4] && !c[3];
    g = '0;
    idle_w = -1;
    if (yl && r[rc])          g[rc] = 1'b1;                 // R4
    else if (r[mslot])        g[mslot] = 1'b1;              // R3 R5
    else if (don && r[rc])    g[rc] = 1'b1;                 // R5
    else begin
      for (int k = 0; k < 8; k++) begin                     // R8 R9
        int j;
        j = (mlast + 1 + k) % 8;
        if (idle_w < 0 && r[j] && mcfg[j][5]) idle_w = j;
      end
      if (idle_w >= 0) g[idle_w] = 1'b1;
    end
  endtask

  task automatic step(input logic [7:0] r, input string tag,
                      input bit we = 0, input int core = 0, input logic [6:0] w = '0);
    exp_t e;
    logic [7:0] g;
    int iw;
    req = r; cfg_we = we; cfg_core = 3'(core); cfg_word = w;
    model(r, g, iw);
    e.grant = g; e.slot = mslot; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    if (we) mcfg[core] = w;                                 // R11
    if (iw >= 0) mlast = iw;
    mslot = (mslot + 1) % 8;
    cfg_we = 1'b0;
  endtask

  task automatic wait_slot(input int s);
    while (mslot != s) step(8'h00, "R10 idle");
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (grant !== e.grant || int'(slot) != e.slot) begin
        failures++;
        $display("FAIL %s: grant=%b slot=%0d expected grant=%b slot=%0d",
                 e.tag, grant, slot, e.grant, e.slot);
      end
    end
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mcfg[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (slot !== 3'd0 || grant !== 8'h00) begin
      failures++;
      $display("FAIL R1: slot=%0d grant=%b expected slot=0 grant=0", slot, grant);
    end
    rst_n = 1'b1;
    // R1 R2 R3: all request, owner served in rotation
    for (int i = 0; i < 9; i++) step(8'hFF, "R1 R2 R3 rotation");
    // R7: yield from core 0 to core 3, core 3 not accepting
    step(8'h00, "R11 write", 1, 0, 7'h13);
    wait_slot(0);
    step(8'h09, "R7 not accepted, owner wins");
    wait_slot(0);
    step(8'h08, "R7 not accepted, idle");
    // R4: core 3 accepts
    step(8'h00, "R11 write", 1, 3, 7'h40);
    wait_slot(0);
    step(8'h09, "R4 yield recipient first");
    wait_slot(0);
    step(8'h01, "R4 owner when recipient idle");
    // R5: core 1 gifts to core 3 (written in slot 1, effective from slot 2)
    step(8'h00, "R11 write", 1, 1, 7'h0B);
    wait_slot(1);
    step(8'h0A, "R5 gift owner first");
    wait_slot(1);
    step(8'h08, "R5 gift recipient when owner idle");
    // R6: core 2 sets both bits
    step(8'h00, "R11 write", 1, 2, 7'h1B);
    wait_slot(2);
    step(8'h0C, "R6 both bits act as gift");
    wait_slot(2);
    step(8'h08, "R6 recipient when owner idle");
    // R7: donation to self ignored
    step(8'h00, "R11 write", 1, 4, 7'h5C);
    wait_slot(4);
    step(8'h10, "R7 self donation");
    // R8: no claim-idle yet
    wait_slot(5);
    step(8'h40, "R8 no claim without bit");
    // R8 R9: cores 5 and 6 claim idle
    step(8'h00, "R11 write", 1, 5, 7'h20);
    step(8'h00, "R11 write", 1, 6, 7'h20);
    wait_slot(4);
    step(8'h60, "R8 R9 first claimer after reset");
    wait_slot(7);
    step(8'h60, "R9 next claimer");
    step(8'h60, "R9 yield recipient idle, claimers rotate");
    step(8'h60, "R9 rotation continues");
    step(8'h10, "R8 core without bit");
    step(8'h00, "R10 no requests");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule